// File: doc/BRIEF.md
# Countdown Event Timer

A single-channel event timer on a simple peripheral bus (APB-style setup and access phases). Software places a 64-bit reload value in two 32-bit word registers, chooses a mode and enables the timer through a control register. While the timer is enabled, it counts down by one on every pulse of a separate timer-tick enable. When the count has reached zero, the next tick is an expiry. An expiry sets a sticky pending flag, and software clears that flag by writing a 1 to it.

In the periodic mode the counter reloads itself on each expiry, so a reload value of N gives one event every N+1 ticks. In the one-time mode the counter stops at zero after one expiry and stays there until software disables and then re-enables it. The interrupt line is the pending flag gated by an unmask bit. The usual sequence is: clear the control register, write the low word, write the high word, then write the control register with the enable, the mode and the unmask bit.

Top module: `evt_timer`

## Requirements
- R1: After reset every readable register reads 0 and the interrupt output is low.
- R2: The low reload word at offset 0x00 and the high reload word at offset 0x04 store full 32-bit writes and read back what was written.
- R3: The control register at offset 0x10 stores write bits [2:0]: bit 0 enables, bit 1 selects the mode (0 periodic, 1 one-time), and bit 2 unmasks. Bits [31:3] read as 0 whatever was written to them.
- R4: On the first clock after the enable bit goes from 0 to 1, the counter takes the value {high word, low word}. After that, each tick decrements it, and clocks without a tick leave it unchanged.
- R5: In periodic mode, with ticks on every clock, a reload value of N gives one expiry every N+1 ticks.
- R6: In one-time mode the counter expires once and then stays at zero. Only clearing the enable bit and setting it again starts a new count.
- R7: The pending flag is bit 0 of offset 0x18. It stays set until a write to 0x18 with bit 0 equal to 1 clears it. A write with bit 0 equal to 0 leaves it unchanged.
- R8: When an expiry and a clearing write fall on the same clock, the flag ends up set.
- R9: The interrupt output is high exactly when the pending flag is 1 and the unmask bit is 1.
- R10: Writes to any other offset change nothing, and reads from any other offset return 0.
- R11: While the enable bit is 0, no tick changes the count and no expiry happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from the offset |
| tick | input | 1 | Timer-clock enable; one decrement per high cycle |
| irq | output | 1 | Event interrupt, level |

## Verification
The counter's state is visible only through the time of the next expiry. A wrong reload, a missed decrement or a one-time counter that restarts therefore shows up as a pending flag, and so an interrupt, on the wrong clock. The bench runs a reference model on every clock and compares the interrupt line against it, so an error becomes visible no later than the first expiry after it. With a short reload value that is within a few ticks. Register faults show up on the next read of the register concerned. A fault in the set/clear priority shows up as the flag dropping on a clock where an expiry and a clearing write coincide.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int WORD_W = 32;

    // Byte offsets decoded by the register file
    localparam int OFS_LOAD_LO = 'h00;
    localparam int OFS_LOAD_HI = 'h04;
    localparam int OFS_CTRL    = 'h10;
    localparam int OFS_STATUS  = 'h18;

    typedef enum logic {
        MODE_PERIODIC = 1'b0,
        MODE_ONE_TIME = 1'b1
    } mode_e;

    // Packed MSB first: bit 2 unmask, bit 1 mode, bit 0 run
    typedef struct packed {
        logic  unmask;
        mode_e mode;
        logic  run;
    } ctrl_t;

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DW-1:0]     pwdata,
    output logic [DW-1:0]     prdata,
    output logic [2*DW-1:0]   load_o,
    output ctrl_t             ctrl_o,
    output logic              clr_o,
    input  logic              status_i
);

    localparam int CTRL_W = $bits(ctrl_t);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_LOAD_LO);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_LOAD_HI);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        ctrl_t         ctrl;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_acc;
    logic  mapped;

    assign wr_acc = psel & penable & pwrite;
    assign mapped = (paddr == A_LO) || (paddr == A_HI) ||
                    (paddr == A_CTRL) || (paddr == A_STAT);

    always_comb begin
        regs_d = regs_q;
        clr_o  = 1'b0;
        if (wr_acc) begin
            if (paddr == A_LO)   regs_d.lo   = pwdata;
            if (paddr == A_HI)   regs_d.hi   = pwdata;
            if (paddr == A_CTRL) regs_d.ctrl = ctrl_t'(pwdata[CTRL_W-1:0]);
            if (paddr == A_STAT) clr_o       = pwdata[0];
        end
    end

    always_comb begin
        prdata = '0;
        if (paddr == A_LO)   prdata = regs_q.lo;
        if (paddr == A_HI)   prdata = regs_q.hi;
        if (paddr == A_CTRL) prdata = {{(DW-CTRL_W){1'b0}}, regs_q.ctrl};
        if (paddr == A_STAT) prdata = {{(DW-1){1'b0}}, status_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign load_o = {regs_q.hi, regs_q.lo};
    assign ctrl_o = regs_q.ctrl;

    // R2: the low word moves only on a write to its own offset
    p_lo_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && (paddr == A_LO)) |=> $stable(load_o[DW-1:0]));

    // R10: unmapped offsets read as zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !mapped) |-> (prdata == '0));

    // R10: a write to an unmapped offset leaves the control bits alone
    p_unmapped_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !mapped) |=> $stable(ctrl_o));

endmodule

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             once_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run_prev;
        logic             done;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        expire_o      = 1'b0;
        st_d.run_prev = run_i;
        if (run_i) begin
            if (!st_q.run_prev) begin
                st_d.cnt  = load_i;
                st_d.done = 1'b0;
            end else if (tick_i && !st_q.done) begin
                if (st_q.cnt == '0) begin
                    expire_o = 1'b1;
                    if (once_i) st_d.done = 1'b1;
                    else        st_d.cnt  = load_i;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: a stopped timer holds its count
    p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(st_q.cnt));

    // R4: enable edge captures the reload value
    p_load_on_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |=> (st_q.cnt == $past(load_i)));

    // R4: a tick on a non-zero running count decrements it by one
    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && st_q.run_prev && tick_i && !st_q.done && st_q.cnt != '0)
        |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R6: a finished one-time count never expires again
    p_single_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && st_q.run_prev && run_i) |-> !expire_o);

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clr_i,
    input  logic unmask_i,
    output logic status_o,
    output logic irq_o
);

    typedef struct packed {
        logic pend;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (expire_i)   st_d.pend = 1'b1;
        else if (clr_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.pend;
    assign irq_o    = st_q.pend & unmask_i;

    // R8: an expiry always leaves the flag set, clear or not
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> status_o);

    // R7: without a clear the flag stays set
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !clr_i) |=> status_o);

    // R9: the line never rises without a pending flag
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> status_o);

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              tick,
    output logic              irq
);

    localparam int CNT_W = 2 * WORD_W;

    logic [CNT_W-1:0] load_val;
    ctrl_t            ctrl;
    logic             clr_req;
    logic             status;
    logic             expire;

    evt_timer_regs #(.ADDR_W(ADDR_W), .DW(WORD_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .load_o   (load_val),
        .ctrl_o   (ctrl),
        .clr_o    (clr_req),
        .status_i (status)
    );

    evt_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (ctrl.run),
        .once_i   (ctrl.mode == MODE_ONE_TIME),
        .tick_i   (tick),
        .load_i   (load_val),
        .expire_o (expire)
    );

    evt_timer_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .clr_i    (clr_req),
        .unmask_i (ctrl.unmask),
        .status_o (status),
        .irq_o    (irq)
    );

endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        tick = 1'b0;
    logic        irq;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int tick_mode = 0;      // 0 every clock, 1 every other clock, 2 none
    bit finished = 1'b0;

    // reference model state
    logic [31:0] m_lo, m_hi;
    logic [2:0]  m_ctrl;
    logic        m_stat, m_prev, m_done, m_exp, m_wr, m_clr;
    logic [63:0] m_cnt;
    int          m_coinc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer #(.ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .tick(tick), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference, advanced on every clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_ctrl = 0; m_stat = 0;
            m_prev = 0; m_done = 0; m_cnt = 0;
        end else begin
            cyc++;
            m_wr  = psel && penable && pwrite;
            m_clr = m_wr && paddr == 8'h18 && pwdata[0];
            m_exp = 1'b0;
            if (m_ctrl[0] && m_prev && tick && !m_done && m_cnt == 0)
                m_exp = 1'b1;
            if (m_exp && m_clr) m_coinc++;
            if (m_ctrl[0]) begin
                if (!m_prev) begin
                    m_cnt = {m_hi, m_lo}; m_done = 0;
                end else if (tick && !m_done) begin
                    if (m_cnt != 0)      m_cnt = m_cnt - 1;
                    else if (m_ctrl[1])  m_done = 1;
                    else                 m_cnt = {m_hi, m_lo};
                end
            end
            m_prev = m_ctrl[0];
            if (m_exp)      m_stat = 1;
            else if (m_clr) m_stat = 0;
            if (m_wr && paddr == 8'h00) m_lo = pwdata;
            if (m_wr && paddr == 8'h04) m_hi = pwdata;
            if (m_wr && paddr == 8'h10) m_ctrl = pwdata[2:0];
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_lo;
            8'h04:   return m_hi;
            8'h10:   return {29'd0, m_ctrl};
            8'h18:   return {31'd0, m_stat};
            default: return 32'd0;
        endcase
    endfunction

    // R9: interrupt line against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !finished)
            chk(irq === (m_stat & m_ctrl[2]), "R9 irq vs model", irq, m_stat & m_ctrl[2]);
    end

    always @(negedge clk) begin
        case (tick_mode)
            0:       tick <= 1'b1;
            1:       tick <= ~tick;
            default: tick <= 1'b0;
        endcase
    end

    always @(posedge clk) begin
        if (cyc > WATCHDOG && !finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk);
        penable = 1;
        #1;
        d = prdata;
        chk(d === m_read(a), "read vs model", d, m_read(a));
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic wait_irq(input int limit, output int at, output bit seen);
        seen = 0; at = 0;
        for (int i = 0; i < limit && !seen; i++) begin
            @(negedge clk);
            if (irq) begin seen = 1; at = cyc; end
        end
    endtask

    task automatic restart(input logic [31:0] lo, input logic [31:0] hi,
                           input logic [2:0] c);
        bus_write(8'h10, 32'h0);
        bus_write(8'h18, 32'h1);
        bus_write(8'h00, lo);
        bus_write(8'h04, hi);
        bus_write(8'h10, {29'd0, c});
    endtask

    initial begin
        logic [31:0] rd;
        int t1, t2;
        bit seen;

        tick_mode = 2;
        repeat (3) @(negedge clk);
        chk(irq === 1'b0, "R1 irq in reset", irq, 0);
        rst_n = 1'b1;

        // R1 reset values
        bus_read(8'h00, rd); chk(rd === 0, "R1 low word", rd, 0);
        bus_read(8'h04, rd); chk(rd === 0, "R1 high word", rd, 0);
        bus_read(8'h10, rd); chk(rd === 0, "R1 control", rd, 0);
        bus_read(8'h18, rd); chk(rd === 0, "R1 status", rd, 0);

        // R2 word storage
        bus_write(8'h00, 32'hDEAD_BEEF);
        bus_write(8'h04, 32'h1234_5678);
        bus_read(8'h00, rd); chk(rd === 32'hDEAD_BEEF, "R2 low word", rd, 32'hDEAD_BEEF);
        bus_read(8'h04, rd); chk(rd === 32'h1234_5678, "R2 high word", rd, 32'h1234_5678);

        // R3 control bits, upper bits zero
        bus_write(8'h10, 32'hFFFF_FFFA);
        bus_read(8'h10, rd); chk(rd === 32'h2, "R3 control masked", rd, 32'h2);
        bus_write(8'h10, 32'h0);

        // R10 unmapped offsets
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h0C, 32'h7);
        bus_write(8'h14, 32'h5);
        bus_read(8'h08, rd); chk(rd === 0, "R10 unmapped read", rd, 0);
        bus_read(8'h10, rd); chk(rd === 0, "R10 control untouched", rd, 0);
        bus_read(8'h00, rd); chk(rd === 32'hDEAD_BEEF, "R10 low word untouched", rd, 32'hDEAD_BEEF);

        // R5 periodic interval with continuous ticks
        tick_mode = 0;
        restart(32'd9, 32'd0, 3'b101);
        wait_irq(60, t1, seen); chk(seen, "R5 first expiry", seen, 1);
        bus_write(8'h18, 32'h1);
        wait_irq(60, t2, seen);
        chk(t2 - t1 == 10, "R5 period N+1", t2 - t1, 10);

        // R4 gated ticks stretch the period
        tick_mode = 1;
        restart(32'd4, 32'd0, 3'b101);
        wait_irq(60, t1, seen); chk(seen, "R4 expiry with gated ticks", seen, 1);
        bus_write(8'h18, 32'h1);
        wait_irq(60, t2, seen);
        chk(t2 - t1 == 10, "R4 five ticks over ten clocks", t2 - t1, 10);

        // R4 no ticks, no expiry
        tick_mode = 2;
        restart(32'd0, 32'd0, 3'b101);
        repeat (20) @(negedge clk);
        bus_read(8'h18, rd); chk(rd === 0, "R4 no tick no expiry", rd, 0);

        // R8 clear coinciding with expiry
        tick_mode = 0;
        restart(32'd3, 32'd0, 3'b101);
        for (int i = 0; i < 12; i++) bus_write(8'h18, 32'h1);
        chk(m_coinc > 0, "R8 coincidence exercised", m_coinc, 1);

        // R6 one-time mode
        restart(32'd3, 32'd0, 3'b111);
        wait_irq(30, t1, seen); chk(seen, "R6 single expiry", seen, 1);
        bus_write(8'h18, 32'h1);
        repeat (25) @(negedge clk);
        chk(irq === 1'b0, "R6 stays stopped", irq, 0);
        bus_read(8'h18, rd); chk(rd === 0, "R6 no second expiry", rd, 0);
        bus_write(8'h10, 32'h0);
        bus_write(8'h10, 32'h7);
        wait_irq(30, t1, seen); chk(seen, "R6 re-enable restarts", seen, 1);

        // R11 disable before expiry
        restart(32'd20, 32'd0, 3'b101);
        bus_write(8'h10, 32'h4);
        repeat (40) @(negedge clk);
        bus_read(8'h18, rd); chk(rd === 0, "R11 no expiry while off", rd, 0);

        // R9 / R7 masked expiry, write-0, write-1
        restart(32'd2, 32'd0, 3'b011);
        repeat (10) @(negedge clk);
        chk(irq === 1'b0, "R9 masked line low", irq, 0);
        bus_read(8'h18, rd); chk(rd === 1, "R7 flag pending", rd, 1);
        bus_write(8'h18, 32'h0);
        bus_read(8'h18, rd); chk(rd === 1, "R7 write 0 keeps flag", rd, 1);
        bus_write(8'h10, 32'h7);
        @(negedge clk);
        chk(irq === 1'b1, "R9 unmask raises line", irq, 1);
        bus_write(8'h18, 32'h1);
        bus_read(8'h18, rd); chk(rd === 0, "R7 write 1 clears", rd, 0);
        chk(irq === 1'b0, "R9 line follows clear", irq, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule